// File: doc/BRIEF.md
# Serial Output Shifter for a FIFO Read Port

This block drains words from the read side of a FIFO and sends them out one bit per serial tick. A word is taken from the storage through a valid/ready handshake whenever the shifter holds nothing. It then leaves on `sdo`, least significant bit first, one bit on each system clock edge where the serial clock enable `sclk_en` is high. The data line has no tristate net. `sdo` comes with an output enable `sdo_oe`, and a receiver or pad should treat `sdo` as undriven while `sdo_oe` is low.

The number of bits sent per word comes from `width_cfg`. The width is captured when the word is fetched, so later changes do not affect a word already in the shifter. When `expand_mode` is set, several devices share one serial line. In that mode every word is nine bits long and the output lets go of the line for one tick after each word. Two status flags are derived from the occupancy that the storage reports and from the shifter's own state:
- `empty_o` says the last word has begun to leave.
- `few_o` warns early that at most one word is left in storage.

Back-pressure rules for the input stream:
- `in_ready` is high exactly when the shifter holds no word.
- A word moves only on a clock edge where `in_valid` and `in_ready` are both high.
- The source may hold `in_valid` high for any number of cycles.
- The shifter never needs `in_valid` to drop, and `in_data` only has to be stable while `in_valid` is high.

Top module: `ser_out_shifter`

## Requirements
- R1: Each word leaves least significant bit first. On the k-th serial tick of a word, counting from 0, `sdo` carries bit k of the word and `sdo_oe` is 1, both visible after that clock edge.
- R2: `width_cfg` (4 bits, unsigned) gives the bits per word when `expand_mode` is 0. Values 1 to 9 are used as given. Values 0 and 10 to 15 mean 9.
- R3: After reset, `sdo_oe` and `sdo` are 0 and `in_ready` is 1. `sdo_oe` stays 0 until the first serial tick at which a bit is sent, even if a word is already held.
- R4: `in_ready` is 1 exactly when no word is held. A word is taken only on an edge with `in_valid` and `in_ready` both high. The next word is fetched on the first edge after the tick that sent the last bit of the current word, provided storage offers one.
- R5: A serial tick while no word is held and no hand-over slot is due drives `sdo_oe` to 0. Sending resumes with bit 0 of the next word fetched.
- R6: When `expand_mode` is 1, every word is 9 bits whatever `width_cfg` holds. The tick after the ninth bit drives `sdo_oe` to 0 and sends no bit, even when the next word is already held.
- R7: `empty_o` is 1 when `stored_level` is 0 and the shifter does not hold a word of which no bit has yet been sent. It therefore rises on the tick that sends bit 0 of the last word.
- R8: `few_o` is 1 when `stored_level` is 0 or 1. It rises once the second-to-last word has been fetched into the shifter.
- R9: The width is captured with the word at fetch time. Changing `width_cfg` while a word is being sent does not change how many bits that word has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| sclk_en | input | 1 | Serial tick: one bit moves on each edge where this is high |
| expand_mode | input | 1 | 1 = shared-line mode: 9-bit words and a one-tick hand-over slot |
| width_cfg | input | 4 | Programmed bits per word (0 or above 9 means 9) |
| in_valid | input | 1 | Storage offers a word |
| in_ready | output | 1 | Shifter can take a word |
| in_data | input | 9 | Word offered by storage |
| stored_level | input | 12 | Words currently held in storage |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for `sdo` |
| empty_o | output | 1 | Last word has begun leaving and storage is empty |
| few_o | output | 1 | Storage holds at most one word |

## Verification
The main path is exercised with a table of words that pair bit patterns with the widths 9, 1, 5, 0 and 12, and with shared-line mode.
- Asymmetric patterns catch a reversed bit order or a stuck shift.
- The widths 0 and 12 separate the fall-back-to-9 rule from a plain truncation of the field.
- The tick that follows each word shows whether the bit count stops at the right place.

Directed sequences cover several other cases:
- back-to-back words, which check the fetch timing;
- a width change in the middle of a word;
- shared-line mode with the next word already waiting, so the hand-over slot is not confused with starvation;
- a three-word drain that walks both flags through every step.

// File: rtl/sos_pkg.sv
package sos_pkg;

  // Bits of a word that are sent, after the fall-back rule for out-of-range settings.
  function automatic int unsigned eff_bits(int unsigned cfg, int unsigned max_bits);
    if (cfg == 0 || cfg > max_bits) return max_bits;
    return cfg;
  endfunction

endpackage

// File: rtl/sos_width.sv
module sos_width #(
  parameter int WORD_W = 9,
  parameter int CFG_W  = 4,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic [CFG_W-1:0] width_cfg,
  input  logic             expand_mode,
  output logic [CNT_W-1:0] bits_eff
);
  import sos_pkg::*;

  always_comb begin
    if (expand_mode) bits_eff = CNT_W'(WORD_W);
    else             bits_eff = CNT_W'(eff_bits(int'(width_cfg), WORD_W));
  end

  // R2
  always_comb begin
    width_range_chk: assert (bits_eff >= 1 && int'(bits_eff) <= WORD_W)
      else $error("effective width out of range");
  end

endmodule

// File: rtl/sos_shreg.sv
module sos_shreg #(
  parameter int WORD_W = 9,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              expand_mode,
  input  logic [CNT_W-1:0]  bits_eff,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              held,
  output logic              started
);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  left_q;
  logic              gap_q;

  assign in_ready = !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      left_q  <= '0;
      gap_q   <= 1'b0;
      held    <= 1'b0;
      started <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      if (tick) begin
        if (gap_q) begin
          sdo_oe <= 1'b0;
          gap_q  <= 1'b0;
        end else if (held) begin
          sdo     <= shift_q[0];
          sdo_oe  <= 1'b1;
          shift_q <= shift_q >> 1;
          started <= 1'b1;
          if (left_q == CNT_W'(1)) begin
            held    <= 1'b0;
            started <= 1'b0;
            gap_q   <= expand_mode;
          end else begin
            left_q <= left_q - CNT_W'(1);
          end
        end else begin
          sdo_oe <= 1'b0;
        end
      end
      if (in_valid && in_ready) begin
        shift_q <= in_data;
        left_q  <= bits_eff;
        held    <= 1'b1;
        started <= 1'b0;
      end
    end
  end

  // R3
  oe_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(tick));

  // R4
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5
  starve_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !held && !gap_q) |=> !sdo_oe);

  // R6
  handover_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap_q) |=> !sdo_oe);

endmodule

// File: rtl/sos_flags.sv
module sos_flags #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] stored_level,
  input  logic             held,
  input  logic             started,
  output logic             empty_o,
  output logic             few_o
);

  logic fresh_word;

  assign fresh_word = held && !started;
  assign empty_o    = (stored_level == '0) && !fresh_word;
  assign few_o      = (stored_level <= LVL_W'(1));

  // R7
  empty_implies_few_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> few_o);

  // R8
  few_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_level > LVL_W'(1)) |-> (!few_o && !empty_o));

endmodule

// File: rtl/ser_out_shifter.sv
module ser_out_shifter #(
  parameter int WORD_W = 9,
  parameter int CFG_W  = 4,
  parameter int LVL_W  = 12,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_en,
  input  logic              expand_mode,
  input  logic [CFG_W-1:0]  width_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LVL_W-1:0]  stored_level,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              empty_o,
  output logic              few_o
);

  logic [CNT_W-1:0] bits_eff;
  logic             held;
  logic             started;

  sos_width #(.WORD_W(WORD_W), .CFG_W(CFG_W)) u_width (
    .width_cfg   (width_cfg),
    .expand_mode (expand_mode),
    .bits_eff    (bits_eff)
  );

  sos_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (sclk_en),
    .expand_mode (expand_mode),
    .bits_eff    (bits_eff),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .held        (held),
    .started     (started)
  );

  sos_flags #(.LVL_W(LVL_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .stored_level (stored_level),
    .held         (held),
    .started      (started),
    .empty_o      (empty_o),
    .few_o        (few_o)
  );

endmodule

// File: tb/tb_ser_out_shifter.sv
`timescale 1ns/1ps
module tb_ser_out_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_en = 1'b0;
  logic        expand_mode = 1'b0;
  logic [3:0]  width_cfg = 4'd9;
  logic        in_valid;
  logic        in_ready;
  logic [8:0]  in_data;
  logic [11:0] stored_level;
  logic        sdo, sdo_oe, empty_o, few_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // storage model
  logic [8:0]  q [16];
  logic [3:0]  wr_p, rd_p;
  logic [11:0] cnt;
  logic        push_req = 1'b0;
  logic [8:0]  push_data = '0;

  assign in_valid     = (cnt != 0);
  assign in_data      = q[rd_p];
  assign stored_level = cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0; rd_p <= '0; cnt <= '0;
    end else begin
      if (push_req) begin
        q[wr_p] <= push_data;
        wr_p <= wr_p + 4'd1;
      end
      if (in_valid && in_ready) rd_p <= rd_p + 4'd1;
      cnt <= cnt + {11'd0, push_req} - {11'd0, (in_valid && in_ready)};
    end
  end

  ser_out_shifter dut (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .expand_mode(expand_mode),
    .width_cfg(width_cfg), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stored_level(stored_level), .sdo(sdo), .sdo_oe(sdo_oe),
    .empty_o(empty_o), .few_o(few_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [8:0] d);
    @(negedge clk); push_req = 1'b1; push_data = d;
    @(negedge clk); push_req = 1'b0;
  endtask

  // one serial tick; returns at the negedge after the edge that used it
  task automatic tick_once();
    @(negedge clk); sclk_en = 1'b1;
    @(negedge clk); sclk_en = 1'b0;
  endtask

  function automatic int exp_bits(input logic [3:0] cfg, input logic ex);
    if (ex) return 9;
    if (cfg == 0 || cfg > 9) return 9;
    return int'(cfg);
  endfunction

  // {expand, width_cfg, data}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 4'd9,  9'h1A5},
    {1'b0, 4'd1,  9'h001},
    {1'b0, 4'd5,  9'h0F6},
    {1'b0, 4'd0,  9'h12C},
    {1'b0, 4'd12, 9'h0B3},
    {1'b1, 4'd3,  9'h165}
  };

  logic [13:0] e;
  logic [8:0]  w, w2;
  int          nb;

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    check(sdo_oe == 1'b0, "R3 oe after reset", int'(sdo_oe), 0);
    check(sdo == 1'b0, "R3 sdo after reset", int'(sdo), 0);
    check(in_ready == 1'b1, "R4 ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: word held but no tick yet -> still disabled
    width_cfg = 4'd4;
    push_word(9'h00A);
    repeat (3) @(negedge clk);
    check(sdo_oe == 1'b0, "R3 oe before first tick", int'(sdo_oe), 0);
    check(in_ready == 1'b0, "R4 ready low while held", int'(in_ready), 0);
    for (int b = 0; b < 4; b++) begin
      tick_once();
      check(sdo_oe && sdo == w2[0] || (sdo_oe && sdo == 1'((9'h00A >> b) & 1)),
            "R1 first word bit", int'(sdo), int'((9'h00A >> b) & 1));
    end
    tick_once();
    check(sdo_oe == 1'b0, "R5 starve after word", int'(sdo_oe), 0);
    check(in_ready == 1'b1, "R4 ready after last bit", int'(in_ready), 1);

    // table walk: R1 / R2 / R6
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      @(negedge clk);
      expand_mode = e[13];
      width_cfg   = e[12:9];
      w           = e[8:0];
      nb          = exp_bits(e[12:9], e[13]);
      push_word(w);
      for (int b = 0; b < nb; b++) begin
        tick_once();
        check(sdo_oe == 1'b1 && sdo == w[b], "R1 R2 table bit",
              int'({sdo_oe, sdo}), int'({1'b1, w[b]}));
      end
      tick_once();
      check(sdo_oe == 1'b0, e[13] ? "R6 table slot" : "R2 R5 table end",
            int'(sdo_oe), 0);
    end

    // R4: back-to-back words, no gap in normal mode
    @(negedge clk); expand_mode = 1'b0; width_cfg = 4'd3;
    w = 9'h005; w2 = 9'h002;
    push_word(w); push_word(w2);
    check(stored_level == 12'd1, "R4 one fetched one stored", int'(stored_level), 1);
    for (int b = 0; b < 3; b++) begin
      tick_once();
      check(sdo_oe && sdo == w[b], "R4 first of pair", int'(sdo), int'(w[b]));
    end
    for (int b = 0; b < 3; b++) begin
      tick_once();
      check(sdo_oe && sdo == w2[b], "R4 second of pair", int'(sdo), int'(w2[b]));
    end
    tick_once();
    check(sdo_oe == 1'b0, "R5 pair drained", int'(sdo_oe), 0);

    // R6: shared-line slot even with next word waiting
    @(negedge clk); expand_mode = 1'b1; width_cfg = 4'd2;
    w = 9'h1C3; w2 = 9'h0A5;
    push_word(w); push_word(w2);
    for (int b = 0; b < 9; b++) begin
      tick_once();
      check(sdo_oe && sdo == w[b], "R6 nine bits", int'(sdo), int'(w[b]));
    end
    @(negedge clk);
    check(in_ready == 1'b0, "R6 next word held", int'(in_ready), 0);
    tick_once();
    check(sdo_oe == 1'b0, "R6 slot with word held", int'(sdo_oe), 0);
    tick_once();
    check(sdo_oe && sdo == w2[0], "R6 resume bit0", int'(sdo), int'(w2[0]));
    for (int b = 1; b < 9; b++) tick_once();
    tick_once();
    check(sdo_oe == 1'b0, "R6 final slot", int'(sdo_oe), 0);

    // R9: width change mid-word
    @(negedge clk); expand_mode = 1'b0; width_cfg = 4'd3;
    w = 9'h0AD;
    push_word(w);
    tick_once();
    check(sdo == w[0], "R9 bit0", int'(sdo), int'(w[0]));
    width_cfg = 4'd9;
    tick_once(); tick_once();
    check(sdo_oe && sdo == w[2], "R9 bit2", int'(sdo), int'(w[2]));
    tick_once();
    check(sdo_oe == 1'b0, "R9 stops at captured width", int'(sdo_oe), 0);

    // R7 / R8 flag walk with three 2-bit words
    @(negedge clk); width_cfg = 4'd2;
    check(empty_o == 1'b1 && few_o == 1'b1, "R7 R8 idle flags",
          int'({empty_o, few_o}), 3);
    push_word(9'h001); push_word(9'h002); push_word(9'h003);
    @(negedge clk);
    check(stored_level == 12'd2 && few_o == 1'b0, "R8 two stored", int'(few_o), 0);
    check(empty_o == 1'b0, "R7 not empty with two stored", int'(empty_o), 0);
    tick_once(); tick_once();
    @(negedge clk);
    check(few_o == 1'b1 && stored_level == 12'd1, "R8 second-to-last fetched",
          int'(few_o), 1);
    tick_once(); tick_once();
    @(negedge clk);
    check(stored_level == 12'd0 && empty_o == 1'b0, "R7 last word unsent",
          int'(empty_o), 0);
    tick_once();
    check(empty_o == 1'b1, "R7 empty after first bit of last", int'(empty_o), 1);
    tick_once();
    check(empty_o == 1'b1 && few_o == 1'b1, "R7 R8 drained", int'({empty_o, few_o}), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    w2 = '0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule